// File: doc/BRIEF.md
# Counter-Mode Keystream Combiner

This block turns an external forward block cipher into a stream cipher. It builds each counter block from a nonce in the upper half and a running count in the lower half, and sends that block to the cipher. It accepts one data beat per cycle on a valid/ready input. Each beat goes down a delay line as deep as the cipher pipeline, so it arrives at the output in the same cycle as the keystream made from its own counter block. The output is the keystream XORed with the delayed beat. The same path therefore encrypts and decrypts. Running ciphertext back through the block with the same nonce and start count gives back the plaintext.

The nonce and the start count are loaded together by a one-cycle load strobe. A beat consumes a count value only when it is accepted. The block remembers the loaded start value. If an accepted beat would bring the count back round to that value, a sticky wrap error is raised and input is refused until the next load, so a counter block is never issued twice.

Back-pressure rules: `in_ready` is low in a load cycle and while `wrap_err` is set, and high at all other times. The output has no ready signal. The cipher pipeline cannot stall, so the consumer must take every beat in the cycle `out_valid` is high.

Top module: `ctr_stream_combiner`

## Requirements
- R1: After reset, `in_ready` is high, `out_valid` and `wrap_err` are low, and `ks_req_block` is all zeros.
- R2: A cycle with `load_i` high accepts no beat and captures `nonce_i` and `seed_i`. From the next cycle, `ks_req_block` equals {nonce, seed} and `wrap_err` is low.
- R3: `ks_req_block` holds the nonce in its upper NONCE_W bits and the count in its lower COUNT_W bits. `ks_req_valid` is high exactly in the cycles in which a beat is accepted (`in_valid` and `in_ready` both high). In that cycle it presents the block for that beat.
- R4: Each accepted beat advances the count by one, modulo 2^COUNT_W.
- R5: Cycles with no accepted beat leave the count unchanged. This includes idle cycles and beats refused by a low `in_ready`.
- R6: Only a load changes the nonce half. The count increment never alters it.
- R7: `out_valid` is high in exactly the cycles in which `ks_rsp_valid` is high. A beat accepted in cycle k appears LATENCY cycles later. At that point `out_data` equals `ks_rsp_data` XOR that beat's data.
- R8: Output data fed back through the block, after reloading the same nonce and start count, comes out equal to the original input data.
- R9: Suppose a beat is accepted and advancing the count would make it equal to the last loaded start value. Then `wrap_err` is high from the next cycle. It stays high until a load, and `in_ready` stays low for that whole time.
- R10: The cipher stand-in used for checking applies a fixed LATENCY-cycle pipeline. `ks_req_valid` gives the cycle in which the block is to be encrypted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | One-cycle strobe that loads nonce and start count and clears the wrap error |
| nonce_i | input | NONCE_W | Nonce captured on load |
| seed_i | input | COUNT_W | Start count captured on load |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_data | input | NONCE_W+COUNT_W | Plaintext or ciphertext beat |
| ks_req_valid | output | 1 | Counter block to be encrypted this cycle |
| ks_req_block | output | NONCE_W+COUNT_W | Current counter block {nonce, count} |
| ks_rsp_valid | input | 1 | Keystream valid from the cipher |
| ks_rsp_data | input | NONCE_W+COUNT_W | Encrypted counter block from the cipher |
| out_valid | output | 1 | Output beat valid (no back-pressure) |
| out_data | output | NONCE_W+COUNT_W | Keystream XOR delayed input beat |
| wrap_err | output | 1 | Sticky flag: the count came round to its start value |

## Verification
The assertions assume that the cipher behaves as a fixed pipeline of exactly LATENCY stages. Under that assumption, a keystream valid returns only LATENCY cycles after each request. The assertions also assume that `load_i` is a clean strobe driven from registers. The bench builds its stand-in cipher as exactly such a pipeline of LATENCY registers, keyed only by `ks_req_valid`. It drives every input half a cycle away from the active edge. The bench uses a narrow count width, so the wrap case is reached in a few hundred beats.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int unsigned DEF_NONCE_W = 64;
  localparam int unsigned DEF_COUNT_W = 64;
  localparam int unsigned DEF_LATENCY = 10;

  // next count value and whether it lands back on the start value
  function automatic logic wraps_to_start(input logic [127:0] nxt,
                                          input logic [127:0] start);
    return nxt == start;
  endfunction
endpackage

// File: rtl/ctr_count_gen.sv
module ctr_count_gen #(
  parameter int unsigned NONCE_W = 64,
  parameter int unsigned COUNT_W = 64,
  localparam int unsigned BLK_W = NONCE_W + COUNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NONCE_W-1:0] nonce_in,
  input  logic [COUNT_W-1:0] seed_in,
  input  logic               advance,
  output logic [BLK_W-1:0]   block_out,
  output logic               err_out
);
  logic [NONCE_W-1:0] nonce_q;
  logic [COUNT_W-1:0] count_q;
  logic [COUNT_W-1:0] start_q;
  logic               err_q;
  logic [COUNT_W-1:0] count_nxt;
  logic               hit_start;

  assign count_nxt = count_q + COUNT_W'(1);
  assign hit_start = ctr_pkg::wraps_to_start(128'(count_nxt), 128'(start_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nonce_q <= '0;
      count_q <= '0;
      start_q <= '0;
      err_q   <= 1'b0;
    end else if (load) begin
      nonce_q <= nonce_in;
      count_q <= seed_in;
      start_q <= seed_in;
      err_q   <= 1'b0;
    end else if (advance) begin
      count_q <= count_nxt;
      if (hit_start) err_q <= 1'b1;
    end
  end

  assign block_out = {nonce_q, count_q};
  assign err_out   = err_q;
endmodule

// File: rtl/ctr_delay_line.sv
module ctr_delay_line #(
  parameter int unsigned WIDTH = 128,
  parameter int unsigned DEPTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [WIDTH-1:0] in_d,
  output logic             out_v,
  output logic [WIDTH-1:0] out_d
);
  logic             v_q [DEPTH];
  logic [WIDTH-1:0] d_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0;
          d_q[0] <= '0;
        end else begin
          v_q[0] <= in_v;
          d_q[0] <= in_d;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
  end

  assign out_v = v_q[DEPTH-1];
  assign out_d = d_q[DEPTH-1];
endmodule

// File: rtl/ctr_stream_combiner.sv
module ctr_stream_combiner #(
  parameter int unsigned NONCE_W = ctr_pkg::DEF_NONCE_W,
  parameter int unsigned COUNT_W = ctr_pkg::DEF_COUNT_W,
  parameter int unsigned LATENCY = ctr_pkg::DEF_LATENCY,
  localparam int unsigned BLK_W  = NONCE_W + COUNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic [COUNT_W-1:0] seed_i,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BLK_W-1:0]   in_data,
  output logic               ks_req_valid,
  output logic [BLK_W-1:0]   ks_req_block,
  input  logic               ks_rsp_valid,
  input  logic [BLK_W-1:0]   ks_rsp_data,
  output logic               out_valid,
  output logic [BLK_W-1:0]   out_data,
  output logic               wrap_err
);
  logic             take;
  logic             dly_valid;
  logic [BLK_W-1:0] dly_data;

  assign in_ready     = !wrap_err && !load_i;
  assign take         = in_valid && in_ready;
  assign ks_req_valid = take;

  ctr_count_gen #(.NONCE_W(NONCE_W), .COUNT_W(COUNT_W)) i_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_i),
    .nonce_in  (nonce_i),
    .seed_in   (seed_i),
    .advance   (take),
    .block_out (ks_req_block),
    .err_out   (wrap_err)
  );

  ctr_delay_line #(.WIDTH(BLK_W), .DEPTH(LATENCY)) i_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (take),
    .in_d  (in_data),
    .out_v (dly_valid),
    .out_d (dly_data)
  );

  assign out_valid = ks_rsp_valid;
  assign out_data  = ks_rsp_data ^ dly_data;
endmodule

// File: rtl/ctr_stream_combiner_chk.sv
module ctr_stream_combiner_chk #(
  parameter int unsigned NONCE_W = 64,
  parameter int unsigned COUNT_W = 64,
  localparam int unsigned BLK_W  = NONCE_W + COUNT_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_i,
  input logic [NONCE_W-1:0] nonce_i,
  input logic [COUNT_W-1:0] seed_i,
  input logic               ks_req_valid,
  input logic [BLK_W-1:0]   ks_req_block,
  input logic               ks_rsp_valid,
  input logic               dly_valid,
  input logic               wrap_err,
  input logic               in_ready
);
  assert_load_captures_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ks_req_block == {$past(nonce_i), $past(seed_i)}) && !wrap_err);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_req_valid && !load_i) |=>
      ks_req_block[COUNT_W-1:0] == $past(ks_req_block[COUNT_W-1:0]) + COUNT_W'(1));

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ks_req_valid && !load_i) |=> $stable(ks_req_block));

  assert_nonce_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ks_req_block[BLK_W-1:COUNT_W]));

  assert_latency_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ks_rsp_valid == dly_valid);

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_err && !load_i) |=> wrap_err && !in_ready);
endmodule

bind ctr_stream_combiner ctr_stream_combiner_chk #(.NONCE_W(NONCE_W), .COUNT_W(COUNT_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .nonce_i      (nonce_i),
  .seed_i       (seed_i),
  .ks_req_valid (ks_req_valid),
  .ks_req_block (ks_req_block),
  .ks_rsp_valid (ks_rsp_valid),
  .dly_valid    (dly_valid),
  .wrap_err     (wrap_err),
  .in_ready     (in_ready)
);

// File: tb/test_ctr_stream_combiner.sv
module test_ctr_stream_combiner;
  localparam int NW  = 120;
  localparam int CW  = 8;
  localparam int BW  = NW + CW;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [NW-1:0] nonce_i = '0;
  logic [CW-1:0] seed_i = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_data = '0;
  logic          ks_req_valid;
  logic [BW-1:0] ks_req_block;
  logic          ks_rsp_valid;
  logic [BW-1:0] ks_rsp_data;
  logic          out_valid;
  logic [BW-1:0] out_data;
  logic          wrap_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctr_stream_combiner #(.NONCE_W(NW), .COUNT_W(CW), .LATENCY(LAT)) i_ctr_stream_combiner (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .nonce_i(nonce_i), .seed_i(seed_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ks_req_valid(ks_req_valid), .ks_req_block(ks_req_block),
    .ks_rsp_valid(ks_rsp_valid), .ks_rsp_data(ks_rsp_data),
    .out_valid(out_valid), .out_data(out_data), .wrap_err(wrap_err)
  );

  // stand-in cipher (R10): fixed LAT-stage pipeline of a keyed mixing function
  function automatic logic [BW-1:0] ks_f(input logic [BW-1:0] x);
    return {x[95:0], x[127:96]} ^ {4{32'h9E3779B9}} ^ (x >> 3);
  endfunction

  logic          cv [LAT];
  logic [BW-1:0] cd [LAT];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin cv[i] <= 1'b0; cd[i] <= '0; end
    end else begin
      cv[0] <= ks_req_valid;
      cd[0] <= ks_f(ks_req_block);
      for (int i = 1; i < LAT; i++) begin cv[i] <= cv[i-1]; cd[i] <= cd[i-1]; end
    end
  end
  assign ks_rsp_valid = cv[LAT-1];
  assign ks_rsp_data  = cd[LAT-1];

  // output monitor
  logic [BW-1:0] got_d [512];
  int            got_c [512];
  int            got_n = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid && got_n < 512) begin
      got_d[got_n] = out_data;
      got_c[got_n] = cyc;
      got_n = got_n + 1;
    end
  end

  logic [BW-1:0] snt_d [512];
  logic [BW-1:0] snt_b [512];
  int            snt_c [512];
  int            snt_n = 0;

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [NW-1:0] n, input logic [CW-1:0] s);
    @(negedge clk);
    in_valid = 1'b0;
    load_i = 1'b1; nonce_i = n; seed_i = s;
    #1 chk(!in_ready, "R2 ready low in load", BW'(in_ready), '0);
    @(negedge clk);
    load_i = 1'b0;
    #1 chk(ks_req_block == {n, s}, "R2 block after load", ks_req_block, {n, s});
    chk(!wrap_err, "R2 error clear", BW'(wrap_err), '0);
  endtask

  // drive one beat in the current cycle (called right after a negedge)
  task automatic put_beat(input logic [BW-1:0] d);
    in_valid = 1'b1; in_data = d;
    #1;
    chk(ks_req_valid, "R3 request valid", BW'(ks_req_valid), BW'(1));
    snt_d[snt_n] = d; snt_b[snt_n] = ks_req_block; snt_c[snt_n] = cyc;
    snt_n++;
  endtask

  task automatic drain();
    @(negedge clk); in_valid = 1'b0;
    repeat (LAT + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(in_ready, "R1 ready", BW'(in_ready), BW'(1));
    chk(!out_valid, "R1 out_valid", BW'(out_valid), '0);
    chk(!wrap_err, "R1 wrap_err", BW'(wrap_err), '0);
    chk(ks_req_block == '0, "R1 block", ks_req_block, '0);
  endtask

  task automatic t_stream(input logic [NW-1:0] n, input logic [CW-1:0] s);
    logic [BW-1:0] prev;
    do_load(n, s);
    snt_n = 0; got_n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 3 == 2) begin
        in_valid = 1'b0;
        prev = ks_req_block;
        @(negedge clk);
        #1 chk(ks_req_block == prev, "R5 idle keeps count", ks_req_block, prev);
      end
      put_beat({$urandom, $urandom, $urandom, $urandom});
      chk(ks_req_block == {n, CW'(s + CW'(i))}, "R3 R4 R6 block value",
          ks_req_block, {n, CW'(s + CW'(i))});
    end
    drain();
    chk(got_n == snt_n, "R7 output count", BW'(got_n), BW'(snt_n));
    for (int i = 0; i < snt_n && i < got_n; i++) begin
      chk(got_d[i] == (ks_f(snt_b[i]) ^ snt_d[i]), "R7 out data", got_d[i],
          ks_f(snt_b[i]) ^ snt_d[i]);
      chk(got_c[i] == snt_c[i] + LAT, "R7 out timing", BW'(got_c[i]), BW'(snt_c[i] + LAT));
    end
  endtask

  task automatic t_roundtrip(input logic [NW-1:0] n, input logic [CW-1:0] s);
    logic [BW-1:0] plain [32];
    logic [BW-1:0] ciph  [32];
    int k;
    do_load(n, s);
    snt_n = 0; got_n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); put_beat({4{$urandom}}); plain[i] = snt_d[i];
    end
    drain();
    k = got_n;
    for (int i = 0; i < k && i < 16; i++) ciph[i] = got_d[i];
    do_load(n, s);
    snt_n = 0; got_n = 0;
    for (int i = 0; i < k && i < 16; i++) begin
      @(negedge clk); put_beat(ciph[i]);
    end
    drain();
    chk(got_n == 16, "R8 beat count", BW'(got_n), BW'(16));
    for (int i = 0; i < got_n && i < 16; i++)
      chk(got_d[i] == plain[i], "R8 restore", got_d[i], plain[i]);
  endtask

  task automatic t_wrap(input logic [NW-1:0] n, input logic [CW-1:0] s);
    logic [BW-1:0] held;
    do_load(n, s);
    snt_n = 0;
    for (int i = 0; i < 255; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = BW'(i);
    end
    @(negedge clk);
    #1 chk(!wrap_err && in_ready, "R9 no error before last value", BW'(wrap_err), '0);
    in_valid = 1'b1;
    @(negedge clk);
    #1 chk(wrap_err, "R9 error raised", BW'(wrap_err), BW'(1));
    chk(!in_ready, "R9 input refused", BW'(in_ready), '0);
    chk(!ks_req_valid, "R9 no request", BW'(ks_req_valid), '0);
    held = ks_req_block;
    repeat (3) @(negedge clk);
    #1 chk(ks_req_block == held, "R5 refused beats keep count", ks_req_block, held);
    chk(wrap_err, "R9 error sticky", BW'(wrap_err), BW'(1));
    in_valid = 1'b0;
    drain();
    do_load(n, s + CW'(7));
    chk(in_ready, "R9 ready after reload", BW'(in_ready), BW'(1));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_stream({30{4'hA}}, 8'h10);
        t_stream({NW{1'b1}}, 8'hFB);
        t_roundtrip(120'h0123456789ABCDEF0011223344556, 8'h42);
        t_wrap(120'h5A5A, 8'hFE);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule